// File: doc/BRIEF.md
# Byte-Wide Table Access and Flash Programming Controller

This block connects a CPU with an 8-bit data path to a program memory that stores 16-bit words. Software loads a byte pointer one byte register at a time. It then moves single bytes between the memory and an 8-bit transfer latch. A table read copies the byte that the pointer addresses into the latch. A table write copies the latch into a holding buffer of one program block. A separate command then programs the whole buffer into memory, or erases a larger block. An internal down-counter sets how long each operation lasts.

While a program or erase runs, the block raises a stall output for instruction fetch and blanks the fetch data. It also ignores table reads, table writes and new commands. Any of these accesses may start at any byte address, and an optional post-increment moves the pointer after each access. The memory array is behavioural and holds a small parameterised window. The pointer bits above that window are kept but do not select storage.

Top module: `tblflash_ctrl`

## Requirements
- R1: A table read (`tbl_rd`) while idle loads the byte addressed by the low `MEM_BYTE_AW` pointer bits into `lat_q` on the next clock edge. Bytes that are erased or were never programmed read as 0xFF.
- R2: Byte address b lives in word b>>1. Even bytes sit in bits [7:0] and odd bytes in bits [15:8]. `fetch_data` returns the word at `fetch_waddr` with that packing.
- R3: `ptr_wr` writes `ptr_wdata` into one pointer byte chosen by `ptr_sel`: 0 selects bits [7:0], 1 selects bits [15:8], and 2 selects bits [PTR_W-1:16], which takes the low PTR_W-16 data bits. `ptr_sel`=3 leaves the pointer unchanged.
- R4: When `tbl_inc` is high, an accepted table read or write adds one to the pointer, wrapping at 2^PTR_W. A pointer write in the same cycle takes priority over the increment.
- R5: A table write puts `lat_q` into holding slot ptr[2:0]. `cmd_prog` programs all 8 slots into the 8-byte block selected by the pointer with bits [2:0] cleared. Slot j goes to byte base+j, and this overwrites what was there. After the program step, every slot reads 0xFF again.
- R6: `cmd_erase` sets all 64 bytes of the block selected by the pointer with bits [5:0] cleared to 0xFF. Bytes outside that block keep their values. If `cmd_prog` and `cmd_erase` arrive together, the erase is done.
- R7: `cmd_erase` with `cmd_bulk` high is ignored: `busy` stays low and memory is unchanged. `cmd_bulk` on its own also does nothing.
- R8: A command accepted on a clock edge raises `busy` on that edge. `busy` stays high for `PROG_CYCLES` cycles for a program step and `ERASE_CYCLES` cycles for an erase. Memory changes on the edge where `busy` falls, and `done` is high for exactly the following cycle.
- R9: While `busy` is high, `fetch_stall` is high and `fetch_data` is zero.
- R10: While `busy` is high, table reads, table writes and new commands are ignored. The latch, the pointer and the holding buffer do not change through them, and no second operation follows.
- R11: After reset the pointer and the latch are zero, `busy` and `done` are low, and all memory and holding bytes are 0xFF.
- R12: `lat_wr` loads `lat_wdata` into the latch. If a table read is accepted in the same cycle, the read takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Write one pointer byte |
| ptr_sel | input | 2 | Pointer byte select (0 low, 1 high, 2 upper) |
| ptr_wdata | input | 8 | Pointer byte data |
| ptr_q | output | PTR_W | Current byte pointer |
| lat_wr | input | 1 | Load transfer latch from CPU |
| lat_wdata | input | 8 | Latch load data |
| lat_q | output | 8 | Transfer latch |
| tbl_rd | input | 1 | Table read request |
| tbl_wr | input | 1 | Table write request |
| tbl_inc | input | 1 | Post-increment pointer on this access |
| cmd_prog | input | 1 | Start block program |
| cmd_erase | input | 1 | Start block erase |
| cmd_bulk | input | 1 | Whole-array erase qualifier (always refused) |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle completion pulse |
| fetch_stall | output | 1 | Instruction fetch must wait |
| fetch_waddr | input | MEM_BYTE_AW-1 | Instruction fetch word address |
| fetch_data | output | 16 | Instruction fetch word |

## Verification
The hardest situation to reach is a set of accesses that arrive while an operation is running. A read, a latch-backed write and a second command all land inside the busy window, and the stimulus must also show that none of them leaked into the pointer, the latch or the holding buffer. The bench starts an erase and then issues each of these accesses in the following cycles. It keeps counting busy cycles across them. Afterwards it programs a block from the untouched buffer and reads it back, which would expose a byte that slipped into the buffer during the busy window. A table write that starts at an unaligned address and wraps the slot index shows the slot mapping in the same readback.

// File: rtl/tblflash_pkg.sv
package tblflash_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2
    } seq_mode_e;

    localparam logic [1:0] PSEL_LOW   = 2'd0;
    localparam logic [1:0] PSEL_HIGH  = 2'd1;
    localparam logic [1:0] PSEL_UPPER = 2'd2;

endpackage

// File: rtl/tblflash_ptr.sv
module tblflash_ptr
    import tblflash_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [7:0]       wdata,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    localparam int UPPER_W = PTR_W - 16;

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            unique case (sel)
                PSEL_LOW:   ptr_d[7:0]        = wdata;
                PSEL_HIGH:  ptr_d[15:8]       = wdata;
                PSEL_UPPER: ptr_d[PTR_W-1:16] = wdata[UPPER_W-1:0];
                default:    ptr_d             = ptr_q;
            endcase
        end else if (inc) begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/tblflash_hold.sv
module tblflash_hold #(
    parameter int BLK_LOG2 = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [BLK_LOG2-1:0]          idx,
    input  logic [7:0]                   wdata,
    input  logic                         clear,
    output logic [8*(2**BLK_LOG2)-1:0]   hold_flat
);
    localparam int NSLOT = 2 ** BLK_LOG2;

    logic [NSLOT-1:0][7:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clear)      slot_d      = '1;
        else if (wr_en) slot_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '1;
        else        slot_q <= slot_d;
    end

    assign hold_flat = slot_q;
endmodule

// File: rtl/tblflash_seq.sv
module tblflash_seq
    import tblflash_pkg::*;
#(
    parameter int BYTE_AW      = 9,
    parameter int WBLK_LOG2    = 3,
    parameter int EBLK_LOG2    = 6,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_prog,
    input  logic                         start_erase,
    input  logic [BYTE_AW-WBLK_LOG2-1:0] blk_in,
    output logic                         busy,
    output logic                         done,
    output logic                         prog_fire,
    output logic                         erase_fire,
    output logic [BYTE_AW-WBLK_LOG2-1:0] fire_blk
);
    localparam int BLK_W   = BYTE_AW - WBLK_LOG2;
    localparam int SUB_W   = EBLK_LOG2 - WBLK_LOG2;
    localparam int CNT_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk;
        logic             done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        prog_fire  = 1'b0;
        erase_fire = 1'b0;
        unique case (s_q.mode)
            SEQ_IDLE: begin
                if (start_erase) begin
                    s_d.mode = SEQ_ERASE;
                    s_d.cnt  = CNT_W'(ERASE_CYCLES - 1);
                    s_d.blk  = {blk_in[BLK_W-1:SUB_W], {SUB_W{1'b0}}};
                end else if (start_prog) begin
                    s_d.mode = SEQ_PROG;
                    s_d.cnt  = CNT_W'(PROG_CYCLES - 1);
                    s_d.blk  = blk_in;
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    prog_fire  = (s_q.mode == SEQ_PROG);
                    erase_fire = (s_q.mode == SEQ_ERASE);
                    s_d.mode   = SEQ_IDLE;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mode: SEQ_IDLE, cnt: '0, blk: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign busy     = (s_q.mode != SEQ_IDLE);
    assign done     = s_q.done;
    assign fire_blk = s_q.blk;
endmodule

// File: rtl/tblflash_mem.sv
module tblflash_mem #(
    parameter int BYTE_AW   = 9,
    parameter int WBLK_LOG2 = 3,
    parameter int EBLK_LOG2 = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prog_fire,
    input  logic                         erase_fire,
    input  logic [BYTE_AW-WBLK_LOG2-1:0] fire_blk,
    input  logic [8*(2**WBLK_LOG2)-1:0]  hold_flat,
    input  logic [BYTE_AW-2:0]           rd_waddr,
    output logic [15:0]                  rd_word,
    input  logic [BYTE_AW-2:0]           if_waddr,
    output logic [15:0]                  if_word
);
    localparam int WORD_AW = BYTE_AW - 1;
    localparam int NWORDS  = 2 ** WORD_AW;
    localparam int BLK_W   = BYTE_AW - WBLK_LOG2;
    localparam int HW      = 2 ** (WBLK_LOG2 - 1);
    localparam int EW_LOG2 = EBLK_LOG2 - 1;
    localparam int SUB_W   = EBLK_LOG2 - WBLK_LOG2;

    logic [15:0] words [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [WORD_AW-1:0] WA = WORD_AW'(w);
        logic [15:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (erase_fire && (WA[WORD_AW-1:EW_LOG2] == fire_blk[BLK_W-1:SUB_W]))
                word_d = 16'hFFFF;
            else if (prog_fire && (WA[WORD_AW-1:WBLK_LOG2-1] == fire_blk))
                word_d = hold_flat[(w % HW)*16 +: 16];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= 16'hFFFF;
            else        word_q <= word_d;
        end

        assign words[w] = word_q;
    end

    assign rd_word = words[rd_waddr];
    assign if_word = words[if_waddr];
endmodule

// File: rtl/tblflash_ctrl.sv
module tblflash_ctrl
    import tblflash_pkg::*;
#(
    parameter int PTR_W        = 22,
    parameter int MEM_BYTE_AW  = 9,
    parameter int WBLK_LOG2    = 3,
    parameter int EBLK_LOG2    = 6,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ptr_wr,
    input  logic [1:0]             ptr_sel,
    input  logic [7:0]             ptr_wdata,
    output logic [PTR_W-1:0]       ptr_q,
    input  logic                   lat_wr,
    input  logic [7:0]             lat_wdata,
    output logic [7:0]             lat_q,
    input  logic                   tbl_rd,
    input  logic                   tbl_wr,
    input  logic                   tbl_inc,
    input  logic                   cmd_prog,
    input  logic                   cmd_erase,
    input  logic                   cmd_bulk,
    output logic                   busy,
    output logic                   done,
    output logic                   fetch_stall,
    input  logic [MEM_BYTE_AW-2:0] fetch_waddr,
    output logic [15:0]            fetch_data
);
    localparam int BLK_W = MEM_BYTE_AW - WBLK_LOG2;
    localparam int HBITS = 8 * (2 ** WBLK_LOG2);

    typedef struct packed {
        logic [7:0] lat;
    } top_state_t;

    top_state_t t_d, t_q;

    logic                   rd_go, wr_go, step;
    logic                   prog_fire, erase_fire;
    logic [BLK_W-1:0]       fire_blk;
    logic [HBITS-1:0]       hold_flat;
    logic [15:0]            rd_word, if_word;
    logic [MEM_BYTE_AW-1:0] byte_addr;
    logic [7:0]             rd_byte;

    assign byte_addr = ptr_q[MEM_BYTE_AW-1:0];
    assign rd_go     = tbl_rd && !busy;
    assign wr_go     = tbl_wr && !tbl_rd && !busy;
    assign step      = tbl_inc && (rd_go || wr_go);
    assign rd_byte   = byte_addr[0] ? rd_word[15:8] : rd_word[7:0];

    always_comb begin
        t_d = t_q;
        if (rd_go)       t_d.lat = rd_byte;
        else if (lat_wr) t_d.lat = lat_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign lat_q = t_q.lat;

    tblflash_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ptr_wr),
        .sel   (ptr_sel),
        .wdata (ptr_wdata),
        .inc   (step),
        .ptr   (ptr_q)
    );

    tblflash_hold #(.BLK_LOG2(WBLK_LOG2)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_go),
        .idx       (ptr_q[WBLK_LOG2-1:0]),
        .wdata     (t_q.lat),
        .clear     (prog_fire),
        .hold_flat (hold_flat)
    );

    tblflash_seq #(
        .BYTE_AW      (MEM_BYTE_AW),
        .WBLK_LOG2    (WBLK_LOG2),
        .EBLK_LOG2    (EBLK_LOG2),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (cmd_prog),
        .start_erase (cmd_erase && !cmd_bulk),
        .blk_in      (byte_addr[MEM_BYTE_AW-1:WBLK_LOG2]),
        .busy        (busy),
        .done        (done),
        .prog_fire   (prog_fire),
        .erase_fire  (erase_fire),
        .fire_blk    (fire_blk)
    );

    tblflash_mem #(
        .BYTE_AW   (MEM_BYTE_AW),
        .WBLK_LOG2 (WBLK_LOG2),
        .EBLK_LOG2 (EBLK_LOG2)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_fire  (prog_fire),
        .erase_fire (erase_fire),
        .fire_blk   (fire_blk),
        .hold_flat  (hold_flat),
        .rd_waddr   (byte_addr[MEM_BYTE_AW-1:1]),
        .rd_word    (rd_word),
        .if_waddr   (fetch_waddr),
        .if_word    (if_word)
    );

    assign fetch_stall = busy;
    assign fetch_data  = busy ? 16'h0000 : if_word;
endmodule

// File: rtl/tblflash_chk.sv
module tblflash_chk #(
    parameter int PTR_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ptr_wr,
    input logic [PTR_W-1:0] ptr_q,
    input logic             lat_wr,
    input logic [7:0]       lat_q,
    input logic             cmd_prog,
    input logic             cmd_erase,
    input logic             cmd_bulk,
    input logic             busy,
    input logic             done,
    input logic             fetch_stall,
    input logic [15:0]      fetch_data
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_prog) |=> busy);

    assert_stall_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (fetch_stall && fetch_data == 16'h0000));

    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_wr) |=> (ptr_q == $past(ptr_q)));

    assert_lat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lat_wr) |=> $stable(lat_q));

    assert_bulk_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_erase && cmd_bulk && !cmd_prog) |=> !busy);
endmodule

bind tblflash_ctrl tblflash_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_wr      (ptr_wr),
    .ptr_q       (ptr_q),
    .lat_wr      (lat_wr),
    .lat_q       (lat_q),
    .cmd_prog    (cmd_prog),
    .cmd_erase   (cmd_erase),
    .cmd_bulk    (cmd_bulk),
    .busy        (busy),
    .done        (done),
    .fetch_stall (fetch_stall),
    .fetch_data  (fetch_data)
);

// File: tb/tblflash_ctrl_tb.sv
module tblflash_ctrl_tb;
    localparam int PTR_W = 22;
    localparam int BAW   = 9;
    localparam int WB    = 3;
    localparam int EB    = 6;
    localparam int PC    = 16;
    localparam int EC    = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             ptr_wr = 1'b0;
    logic [1:0]       ptr_sel = '0;
    logic [7:0]       ptr_wdata = '0;
    logic [PTR_W-1:0] ptr_q;
    logic             lat_wr = 1'b0;
    logic [7:0]       lat_wdata = '0;
    logic [7:0]       lat_q;
    logic             tbl_rd = 1'b0, tbl_wr = 1'b0, tbl_inc = 1'b0;
    logic             cmd_prog = 1'b0, cmd_erase = 1'b0, cmd_bulk = 1'b0;
    logic             busy, done, fetch_stall;
    logic [BAW-2:0]   fetch_waddr = '0;
    logic [15:0]      fetch_data;

    tblflash_ctrl #(
        .PTR_W(PTR_W), .MEM_BYTE_AW(BAW), .WBLK_LOG2(WB), .EBLK_LOG2(EB),
        .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) u_dut (.*);

    int n_cmp = 0, n_bad = 0;
    logic [7:0]       mdl [2**BAW];
    logic [7:0]       hold_m [2**WB];
    logic [7:0]       lat_m = '0;
    logic [PTR_W-1:0] ptr_m = '0;
    logic             busy_m = 1'b0;
    logic [7:0]       exp_q [$];
    string            tag_q [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one latch compare per issued table read
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= tbl_rd && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk("R1 unexpected read", 1, 0);
            else chk(tag_q.pop_front(), {24'h0, lat_q}, {24'h0, exp_q.pop_front()});
        end
    end

    task automatic set_ptr(input logic [PTR_W-1:0] v);
        ptr_wr = 1'b1;
        ptr_sel = 2'd0; ptr_wdata = v[7:0];  @(negedge clk);
        ptr_sel = 2'd1; ptr_wdata = v[15:8]; @(negedge clk);
        ptr_sel = 2'd2; ptr_wdata = 8'(v[PTR_W-1:16]); @(negedge clk);
        ptr_wr = 1'b0;
        ptr_m = v;
    endtask

    task automatic rd(input logic inc, input string tag);
        logic [7:0] e;
        e = busy_m ? lat_m : mdl[ptr_m[BAW-1:0]];
        lat_m = e;
        if (!busy_m && inc) ptr_m = ptr_m + 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        tbl_rd = 1'b1; tbl_inc = inc;
        @(negedge clk);
        tbl_rd = 1'b0; tbl_inc = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input logic inc);
        lat_wr = 1'b1; lat_wdata = d; @(negedge clk); lat_wr = 1'b0;
        if (!busy_m) lat_m = d;
        if (!busy_m) begin
            hold_m[ptr_m[WB-1:0]] = lat_m;
            if (inc) ptr_m = ptr_m + 1'b1;
        end
        tbl_wr = 1'b1; tbl_inc = inc; @(negedge clk); tbl_wr = 1'b0; tbl_inc = 1'b0;
    endtask

    task automatic start(input logic p, input logic e, input logic b);
        cmd_prog = p; cmd_erase = e; cmd_bulk = b; @(negedge clk);
        cmd_prog = 1'b0; cmd_erase = 1'b0; cmd_bulk = 1'b0;
    endtask

    // erase_op: 1 erase, 0 program; counts busy cycles left and applies the model
    task automatic finish_op(input logic erase_op, input int exp_left,
                             input logic [PTR_W-1:0] at, input string tag);
        int cnt = 0;
        chk("R9 stall while busy", {31'h0, fetch_stall}, 1);
        chk("R9 fetch blank while busy", {16'h0, fetch_data}, 0);
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(tag, cnt, exp_left);
        chk("R8 done pulse", {31'h0, done}, 1);
        if (erase_op) begin
            for (int j = 0; j < 2**EB; j++) mdl[{at[BAW-1:EB], EB'(j)}] = 8'hFF;
        end else begin
            for (int j = 0; j < 2**WB; j++) mdl[{at[BAW-1:WB], WB'(j)}] = hold_m[j];
            for (int j = 0; j < 2**WB; j++) hold_m[j] = 8'hFF;
        end
        busy_m = 1'b0;
        @(negedge clk);
        chk("R8 done one cycle", {31'h0, done}, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2**BAW; i++) mdl[i] = 8'hFF;
        for (int i = 0; i < 2**WB; i++) hold_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ptr", ptr_q, 0);
        chk("R11 latch", {24'h0, lat_q}, 0);
        chk("R11 busy", {31'h0, busy}, 0);
        chk("R11 done", {31'h0, done}, 0);
        chk("R11 fetch erased", {16'h0, fetch_data}, 32'hFFFF);

        // R3 pointer byte composition and unused select
        set_ptr(22'h15A35C);
        chk("R3 ptr compose", ptr_q, 32'h15A35C);
        ptr_wr = 1'b1; ptr_sel = 2'd2; ptr_wdata = 8'hFF; @(negedge clk);
        ptr_sel = 2'd3; ptr_wdata = 8'h77; @(negedge clk); ptr_wr = 1'b0;
        chk("R3 upper field, sel3 ignored", ptr_q, 32'h3FA35C);

        // R12 latch load
        lat_wr = 1'b1; lat_wdata = 8'h5A; @(negedge clk); lat_wr = 1'b0; lat_m = 8'h5A;
        chk("R12 latch load", {24'h0, lat_q}, 32'h5A);

        // R5 unaligned fill wrapping slot index, R4 increment
        set_ptr(22'h000023);
        for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 1'b1);
        chk("R4 post-increment", ptr_q, 32'h2B);
        set_ptr(22'h000025);
        start(1'b1, 1'b0, 1'b0); busy_m = 1'b1;
        finish_op(1'b0, PC, 22'h25, "R8 program length");

        // R1/R5 readback around block, R2 lane packing
        set_ptr(22'h00001F);
        for (int i = 0; i < 10; i++) rd(1'b1, "R1 R5 readback");
        fetch_waddr = 8'h12; #1;
        chk("R2 word lanes", {16'h0, fetch_data}, {16'h0, mdl[9'h25], mdl[9'h24]});
        fetch_waddr = 8'h10; #1;
        chk("R2 word lanes low", {16'h0, fetch_data}, {16'h0, mdl[9'h21], mdl[9'h20]});

        // R5 buffer cleared after commit: single byte commit
        set_ptr(22'h000041);
        wr(8'hC3, 1'b0);
        start(1'b1, 1'b0, 1'b0); busy_m = 1'b1;
        finish_op(1'b0, PC, 22'h41, "R8 program length 2");
        set_ptr(22'h000040);
        for (int i = 0; i < 3; i++) rd(1'b1, "R5 cleared buffer");

        // R10 accesses and commands during busy, R6 erase
        set_ptr(22'h000020);
        start(1'b0, 1'b1, 1'b0); busy_m = 1'b1;
        rd(1'b1, "R10 read ignored while busy");
        wr(8'hEE, 1'b1);
        start(1'b1, 1'b0, 1'b0);
        chk("R10 ptr held while busy", ptr_q, 32'h20);
        finish_op(1'b1, EC - 4, 22'h20, "R8 erase length");
        chk("R10 no queued command", {31'h0, busy}, 0);
        set_ptr(22'h000020); rd(1'b0, "R6 erased");
        set_ptr(22'h00003F); rd(1'b0, "R6 erased top");
        set_ptr(22'h000041); rd(1'b0, "R6 outside block kept");
        set_ptr(22'h000040);
        start(1'b1, 1'b0, 1'b0); busy_m = 1'b1;
        finish_op(1'b0, PC, 22'h40, "R8 program length 3");
        set_ptr(22'h000040);
        rd(1'b1, "R10 write ignored while busy"); rd(1'b1, "R5 overwrite");

        // R7 bulk refused
        set_ptr(22'h00000A); wr(8'h99, 1'b0);
        start(1'b1, 1'b0, 1'b0); busy_m = 1'b1;
        finish_op(1'b0, PC, 22'h0A, "R8 program length 4");
        start(1'b0, 1'b1, 1'b1);
        chk("R7 bulk no busy", {31'h0, busy}, 0);
        start(1'b0, 1'b0, 1'b1);
        chk("R7 bulk alone no busy", {31'h0, busy}, 0);
        rd(1'b0, "R7 memory kept");

        // R12 read priority over latch load
        exp_q.push_back(8'h99); tag_q.push_back("R12 read wins"); lat_m = 8'h99;
        tbl_rd = 1'b1; lat_wr = 1'b1; lat_wdata = 8'h11; @(negedge clk);
        tbl_rd = 1'b0; lat_wr = 1'b0;

        // R6 erase wins over program
        set_ptr(22'h00000A);
        start(1'b1, 1'b1, 1'b0); busy_m = 1'b1;
        finish_op(1'b1, EC, 22'h0A, "R6 erase priority length");
        rd(1'b0, "R6 erase priority data");

        // R4 wrap
        set_ptr(22'h3FFFFF);
        rd(1'b1, "R4 read at top");
        chk("R4 wrap", ptr_q, 0);

        @(negedge clk);
        chk("R1 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule